// File: doc/BRIEF.md
# Pipelined-Store Data Cache

A direct-mapped data cache of 1 KB, built as 64 lines of four 32-bit words with one tag per line. A load is looked up in the cycle it is presented, and its hit flag and data appear on registered outputs in the next cycle. Stores pass through two stages. The first stage compares the tag. The second stage writes the data array a cycle later, byte by byte. This lets a store be accepted on every clock.

While a store waits in its second stage, a load to the same word must not read the stale array. That load gets the store's enabled bytes merged over the array word. Every store is also passed to a write-through output for the memory side. A store that misses does not allocate a line and leaves the array untouched. Lines are filled from memory through a refill port that takes four words. During a refill the block raises busy and ignores requests.

Top module: `dcache_pipe`

## Requirements
- R1: After reset every line is invalid, so any load misses, and busy, rdValid and wtValid are low.
- R2: A load accepted in cycle N raises rdValid in cycle N+1. rdHit is high when the line selected by address bits [9:4] is valid and its tag equals bits [31:10]. On a hit rdData is the word selected by bits [3:2]. On a miss rdData is 0.
- R3: A store that hits writes only the bytes whose enable is set. Enable bit i covers data bits 8i+7..8i. Later loads return the merged word.
- R4: Every accepted store, hit or miss, appears one cycle later on wtValid, wtAddr, wtBe and wtData with its own address, enables and data.
- R5: A store that misses changes nothing in the cache. The line resident at that index keeps its data and the missed address still misses.
- R6: A load presented in the cycle right after a hitting store to the same word returns the store's enabled bytes merged over the old word.
- R7: A refill consists of four fillValid beats carrying line address fillLine (address bits [31:4]). Beat k writes word k. The line is invalid from the first beat and becomes valid with tag fillLine[27:6] after the fourth beat.
- R8: busy is high in the cycles after refill beats one to three and low after the fourth. A request presented while busy or fillValid is high is ignored and produces neither rdValid nor wtValid.
- R9: Stores presented back to back, one per cycle, each complete and each appears on the write-through output.
- R10: A load right after a store to a different word of the same line returns the array contents without merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Byte address of the request |
| reqBe | input | 4 | Store byte enables |
| reqWdata | input | 32 | Store data |
| rdValid | output | 1 | Load result present |
| rdHit | output | 1 | Load hit |
| rdData | output | 32 | Load data (0 on miss) |
| wtValid | output | 1 | Write-through store present |
| wtAddr | output | 32 | Write-through address |
| wtBe | output | 4 | Write-through byte enables |
| wtData | output | 32 | Write-through data |
| fillValid | input | 1 | Refill beat present |
| fillLine | input | 28 | Line address being refilled |
| fillData | input | 32 | Refill word |
| busy | output | 1 | Refill in progress, requests ignored |

## Verification
Loads run against freshly reset, refilled and partly overwritten lines, so a hit can be told apart from a miss and from a stale word. A store followed at once by a load to the same word tells forwarding apart from a stale array read. The same store followed by a load to a neighbouring word shows that the merge is confined to one word. A sparse enable mask exposes byte-lane errors. A missing store that shares an index with a resident line separates allocate from no-allocate. A request in the middle of a refill shows that busy blocks it.

// File: rtl/dc_pkg.sv
package dc_pkg;
  parameter int ADDR_W     = 32;
  parameter int DATA_W     = 32;
  parameter int LINE_WORDS = 4;
  parameter int NUM_LINES  = 64;
  localparam int BYTES   = DATA_W / 8;
  localparam int BYTE_W  = $clog2(BYTES);
  localparam int WSEL_W  = $clog2(LINE_WORDS);
  localparam int OFF_W   = BYTE_W + WSEL_W;
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W  = ADDR_W - OFF_W;
  localparam int SLOTS   = NUM_LINES * LINE_WORDS;

  typedef struct packed {
    logic              acceptLoad;
    logic              acceptStore;
    logic              fillWrite;
    logic              fillFirst;
    logic              fillLast;
    logic [WSEL_W-1:0] fillWord;
  } dc_strobe_t;
endpackage

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       fillValid,
  output logic       busy,
  output dc_strobe_t strobe
);
  logic [WSEL_W-1:0] beatCnt;
  logic              busyQ;
  logic              accept;

  always_comb begin
    accept             = reqValid && !busyQ && !fillValid;
    strobe.acceptLoad  = accept && !reqWrite;
    strobe.acceptStore = accept && reqWrite;
    strobe.fillWrite   = fillValid;
    strobe.fillFirst   = fillValid && (beatCnt == '0);
    strobe.fillLast    = fillValid && (beatCnt == WSEL_W'(LINE_WORDS - 1));
    strobe.fillWord    = beatCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      busyQ   <= 1'b0;
    end else if (fillValid) begin
      beatCnt <= strobe.fillLast ? '0 : beatCnt + 1'b1;
      busyQ   <= !strobe.fillLast;
    end
  end

  assign busy = busyQ;

  // R8: busy only ever starts right after the first refill beat
  a_r8_busy_starts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strobe.fillFirst));
  // R8: the fourth beat closes the refill
  a_r8_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillLast |=> !busy);
  // R8: nothing is accepted while a refill is open
  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    (busy || fillValid) |-> !(strobe.acceptLoad || strobe.acceptStore));
endmodule

// File: rtl/dcache_dpath.sv
module dcache_dpath
  import dc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dc_strobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BYTES-1:0]  reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [DATA_W-1:0] fillData,
  output logic              rdValid,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData,
  output logic              wtValid,
  output logic [ADDR_W-1:0] wtAddr,
  output logic [BYTES-1:0]  wtBe,
  output logic [DATA_W-1:0] wtData
);
  logic [DATA_W-1:0] dataRam [SLOTS];
  logic [TAG_W-1:0]  tagRam  [NUM_LINES];
  logic [NUM_LINES-1:0] validQ;

  logic              s2Valid, s2Hit;
  logic [ADDR_W-1:0] s2Addr;
  logic [BYTES-1:0]  s2Be;
  logic [DATA_W-1:0] s2Data;

  logic [IDX_W-1:0]        reqIdx, fillIdx;
  logic [TAG_W-1:0]        reqTag, fillTag;
  logic [IDX_W+WSEL_W-1:0] reqSlot, s2Slot;
  logic                    lookupHit, fwdSel;
  logic [DATA_W-1:0]       ramWord, loadWord;

  assign reqIdx    = reqAddr[OFF_W +: IDX_W];
  assign reqTag    = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSlot   = reqAddr[BYTE_W +: IDX_W+WSEL_W];
  assign s2Slot    = s2Addr[BYTE_W +: IDX_W+WSEL_W];
  assign fillIdx   = fillLine[IDX_W-1:0];
  assign fillTag   = fillLine[LINE_W-1 -: TAG_W];
  assign lookupHit = validQ[reqIdx] && (tagRam[reqIdx] == reqTag);
  assign ramWord   = dataRam[reqSlot];
  assign fwdSel    = s2Valid && s2Hit && (s2Slot == reqSlot);

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign loadWord[8*b +: 8] = (fwdSel && s2Be[b]) ? s2Data[8*b +: 8] : ramWord[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Hit   <= 1'b0;
      s2Addr  <= '0;
      s2Be    <= '0;
      s2Data  <= '0;
      rdValid <= 1'b0;
      rdHit   <= 1'b0;
      rdData  <= '0;
      validQ  <= '0;
    end else begin
      s2Valid <= strobe.acceptStore;
      if (strobe.acceptStore) begin
        s2Hit  <= lookupHit;
        s2Addr <= reqAddr;
        s2Be   <= reqBe;
        s2Data <= reqWdata;
      end
      rdValid <= strobe.acceptLoad;
      if (strobe.acceptLoad) begin
        rdHit  <= lookupHit;
        rdData <= lookupHit ? loadWord : '0;
      end
      if (strobe.fillFirst) validQ[fillIdx] <= 1'b0;
      if (strobe.fillLast)  validQ[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (s2Valid && s2Hit) begin
      for (int b = 0; b < BYTES; b++) begin
        if (s2Be[b]) dataRam[s2Slot][8*b +: 8] <= s2Data[8*b +: 8];
      end
    end
    if (strobe.fillWrite) dataRam[{fillIdx, strobe.fillWord}] <= fillData;
    if (strobe.fillFirst) tagRam[fillIdx] <= fillTag;
  end

  assign wtValid = s2Valid;
  assign wtAddr  = s2Addr;
  assign wtBe    = s2Be;
  assign wtData  = s2Data;

  // R2: an accepted load answers in the next cycle and only then
  a_r2_load_reply: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptLoad |=> rdValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strobe.acceptLoad));
  // R4: each store reaches the write-through port with its own address
  a_r4_wt_reply: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptStore |=> (wtValid && wtAddr == $past(reqAddr) && wtData == $past(reqWdata)));
  // R2: a miss returns zero data
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdHit) |-> (rdData == '0));
endmodule

// File: rtl/dcache_pipe.sv
module dcache_pipe
  import dc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BYTES-1:0]  reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData,
  output logic              wtValid,
  output logic [ADDR_W-1:0] wtAddr,
  output logic [BYTES-1:0]  wtBe,
  output logic [DATA_W-1:0] wtData,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [DATA_W-1:0] fillData,
  output logic              busy
);
  dc_strobe_t strobe;

  dcache_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .fillValid(fillValid), .busy(busy), .strobe(strobe)
  );

  dcache_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqWdata(reqWdata), .fillLine(fillLine), .fillData(fillData),
    .rdValid(rdValid), .rdHit(rdHit), .rdData(rdData),
    .wtValid(wtValid), .wtAddr(wtAddr), .wtBe(wtBe), .wtData(wtData)
  );
endmodule

// File: tb/tb_dcache_pipe.sv
module tb_dcache_pipe;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [31:0] reqAddr = 0, reqWdata = 0, fillData = 0;
  logic [3:0]  reqBe = 0;
  logic fillValid = 0;
  logic [27:0] fillLine = 0;
  logic rdValid, rdHit, wtValid, busy;
  logic [31:0] rdData, wtAddr, wtData;
  logic [3:0] wtBe;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dcache_pipe dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdHit(rdHit), .rdData(rdData),
    .wtValid(wtValid), .wtAddr(wtAddr), .wtBe(wtBe), .wtData(wtData),
    .fillValid(fillValid), .fillLine(fillLine), .fillData(fillData), .busy(busy)
  );

  // behavioural reference: architectural cache state updated at acceptance
  logic [31:0] mData [256];
  logic [21:0] mTag [64];
  bit          mValid [64];
  int          mBeat;
  bit          eBusy, eRdValid, eRdHit, eWtValid;
  logic [31:0] eRdData, eWtAddr, eWtData;
  logic [3:0]  eWtBe;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mValid[i] = 0;
      mBeat = 0; eBusy = 0; eRdValid = 0; eWtValid = 0; eRdHit = 0; eRdData = 0;
    end else begin
      int idx, slot;
      bit hit, acc;
      idx  = int'(reqAddr[9:4]);
      slot = idx * 4 + int'(reqAddr[3:2]);
      hit  = mValid[idx] && (mTag[idx] == reqAddr[31:10]);
      acc  = reqValid && !eBusy && !fillValid;
      eRdValid = acc && !reqWrite;
      eWtValid = acc && reqWrite;
      if (eRdValid) begin
        eRdHit  = hit;
        eRdData = hit ? mData[slot] : 32'h0;
      end
      if (eWtValid) begin
        eWtAddr = reqAddr; eWtBe = reqBe; eWtData = reqWdata;
        if (hit)
          for (int b = 0; b < 4; b++)
            if (reqBe[b]) mData[slot][8*b +: 8] = reqWdata[8*b +: 8];
      end
      if (fillValid) begin
        int fi;
        fi = int'(fillLine[5:0]);
        if (mBeat == 0) begin mValid[fi] = 0; mTag[fi] = fillLine[27:6]; end
        mData[fi * 4 + mBeat] = fillData;
        if (mBeat == 3) begin mValid[fi] = 1; mBeat = 0; eBusy = 0; end
        else begin mBeat = mBeat + 1; eBusy = 1; end
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busy == eBusy, "R8 busy", {31'b0, busy}, {31'b0, eBusy});
      check(rdValid == eRdValid, "R2 rdValid", {31'b0, rdValid}, {31'b0, eRdValid});
      if (rdValid && eRdValid) begin
        check(rdHit == eRdHit, "R2 rdHit", {31'b0, rdHit}, {31'b0, eRdHit});
        check(rdData == eRdData, "R6 rdData", rdData, eRdData);
      end
      check(wtValid == eWtValid, "R4 wtValid", {31'b0, wtValid}, {31'b0, eWtValid});
      if (wtValid && eWtValid) begin
        check(wtAddr == eWtAddr, "R4 wtAddr", wtAddr, eWtAddr);
        check(wtBe == eWtBe, "R4 wtBe", {28'b0, wtBe}, {28'b0, eWtBe});
        check(wtData == eWtData, "R4 wtData", wtData, eWtData);
      end
    end
  end

  task automatic req(bit v, bit w, logic [31:0] a, logic [3:0] be, logic [31:0] d);
    reqValid = v; reqWrite = w; reqAddr = a; reqBe = be; reqWdata = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic load_expect(logic [31:0] a, bit h, logic [31:0] d, string tag);
    req(1, 0, a, 4'h0, 32'h0);
    check(rdValid && rdHit == h, tag, {31'b0, rdHit}, {31'b0, h});
    check(rdData == d, tag, rdData, d);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
          bad++; total++;
          $display("FAIL watchdog expired");
          finished = 1;
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(!busy && !rdValid && !wtValid, "R1 idle", {29'b0, busy, rdValid, wtValid}, 32'h0);
    load_expect(32'h0000_1230, 0, 32'h0, "R1 miss after reset");

    // R7 / R8: refill line 0x1230 with a request dropped mid-refill
    for (int k = 0; k < 4; k++) begin
      fillValid = 1; fillLine = 28'h000_0123; fillData = 32'hA0A0_0000 | k;
      if (k == 2) begin reqValid = 1; reqWrite = 0; reqAddr = 32'h0000_1230; end
      @(negedge clk);
      reqValid = 0;
      if (k < 3) check(busy, "R8 busy during refill", {31'b0, busy}, 32'h1);
      if (k == 2) check(!rdValid, "R8 ignored while filling", {31'b0, rdValid}, 32'h0);
    end
    fillValid = 0;
    check(!busy, "R8 busy clears", {31'b0, busy}, 32'h0);
    load_expect(32'h0000_1238, 1, 32'hA0A0_0002, "R7 refilled word 2");
    req(1, 0, 32'h0000_1230, 4'h0, 32'h0);
    check(rdValid && rdHit && rdData == 32'hA0A0_0000, "R7 refilled word 0", rdData, 32'hA0A0_0000);

    // R6 / R3: byte-enabled store then immediate load of the same word
    req(1, 1, 32'h0000_1234, 4'b0101, 32'hDEAD_BEEF);
    check(wtValid && wtAddr == 32'h0000_1234 && wtBe == 4'b0101, "R4 wt fields", wtAddr, 32'h0000_1234);
    load_expect(32'h0000_1234, 1, 32'hA0AD_00EF, "R6 forwarded merge");
    load_expect(32'h0000_1234, 1, 32'hA0AD_00EF, "R3 merged in array");

    // R5: miss on same index, other tag
    req(1, 1, 32'h0000_5230, 4'hF, 32'h1234_5678);
    check(wtValid && wtData == 32'h1234_5678, "R5 miss still written through", wtData, 32'h1234_5678);
    load_expect(32'h0000_1230, 1, 32'hA0A0_0000, "R5 resident line untouched");
    load_expect(32'h0000_5230, 0, 32'h0, "R5 no allocate");

    // R9: back-to-back stores to all four words
    for (int k = 0; k < 4; k++) begin
      req(1, 1, 32'h0000_1230 + 4 * k, 4'hF, 32'h0000_00C0 + k);
      check(wtValid && wtAddr == 32'h0000_1230 + 4 * k, "R9 store each cycle", wtAddr, 32'h0000_1230 + 4 * k);
    end
    // R10: load right after store to another word of the line
    load_expect(32'h0000_1234, 1, 32'h0000_00C1, "R10 no cross-word merge");
    for (int k = 0; k < 4; k++)
      load_expect(32'h0000_1230 + 4 * k, 1, 32'h0000_00C0 + k, "R9 stored word");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule